// File: doc/BRIEF.md
# Reversible First-Order IIR Pipeline Stage

This block is one stage of a linear chain of identical first-order recursive filter sections. Each stage computes y(n) = a0·x(n) + a1·x(n-1) − b1·y(n-1) on 8-bit signed fractional samples. A stage receives samples from one neighbour and passes results on to the other. A strobe marks each valid sample on the bus between neighbours. Setting b1 to zero turns the stage into a plain FIR tap. A chain of N stages applies N sections per pass. To apply more sections, the chain is run again with the data flowing the other way.

Every stage plays one of three roles in a pass. A reader streams samples out of its local memory into the chain. A propagator filters the samples it receives and forwards them. A writer filters the samples it receives and stores the results in its local memory. At each `start` the stage fetches a header from local memory: a configuration byte, the sample count and one coefficient set. From the second pass on, the stage flips its flow direction. A reader becomes a writer and a writer becomes a reader, so the data can be swept back through the same chain.

Top module: `iirReversibleStage`

## Requirements
- R1: Each accepted sample x produces y = sat((a0·x + a1·x1 − b1·y1) >>> 7). x1 and y1 are the previous accepted input and the previous output of the same pass. The shift is arithmetic. sat clamps the result to [-128, 127].
- R2: A sum whose shifted value lies outside [-128, 127] gives 127 on positive overflow and -128 on negative overflow.
- R3: With b1 = 0, the output depends only on the current input and the previous input.
- R4: A propagator accepts samples only on its upstream side: left when the direction is left-to-right, right otherwise. It presents each result on the opposite side, with the strobe raised exactly one cycle after the input strobe. A strobe on its downstream input causes no output.
- R5: Reset clears all outputs, selects left-to-right flow and selects the Propagate role. The first pass after reset takes its role and direction from memory word 0: bits [1:0] give the role (1 = Read, 2 = Write, any other value = Propagate), and bit 2 gives the direction (0 = left-to-right).
- R6: On every start after the first, the stage inverts its direction bit and swaps Read and Write. A propagator stays a propagator.
- R7: Memory word 1 holds the sample count of a pass. Coefficient set s sits at words 2+3s, 3+3s and 4+3s (a0, a1, b1). With the default two sets, pass p uses set p mod 2, counting from 0 after reset.
- R8: x1 and y1 are cleared to zero before the first sample of every pass.
- R9: A reader reads words 8, 9, ... up to the sample count. It feeds each word through the filter and sends the result downstream with a strobe, and it never reads and writes memory in the same cycle.
- R10: A writer stores the i-th result of a pass at address 8+i and never raises a bus strobe.
- R11: A writer raises `done` for exactly one cycle, in the cycle after the write of the last sample. No other role raises `done`.
- R12: Input strobes that arrive while no pass is running, or while the header is being fetched, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (header fetch, then run) |
| leftInData | input | 8 | Sample from the left neighbour |
| leftInStb | input | 1 | Valid strobe for leftInData |
| rightInData | input | 8 | Sample from the right neighbour |
| rightInStb | input | 1 | Valid strobe for rightInData |
| leftOutData | output | 8 | Result toward the left neighbour |
| leftOutStb | output | 1 | Valid strobe for leftOutData |
| rightOutData | output | 8 | Result toward the right neighbour |
| rightOutStb | output | 1 | Valid strobe for rightOutData |
| memAddr | output | 10 | Local memory address |
| memRdEn | output | 1 | Memory read request (data one cycle later) |
| memRdData | input | 8 | Memory read data |
| memWrEn | output | 1 | Memory write enable |
| memWrData | output | 8 | Memory write data |
| done | output | 1 | Writer end-of-pass pulse |

## Verification
The propagate role is swept over eight coefficient triples, with the passes alternating direction:
- A triple with zero feedback isolates the feed-forward path.
- Triples with both feedback signs expose errors in the subtraction and in the clearing of the delay registers between passes.
- A run of full-scale positive values followed by full-scale negative values drives the sum past both clamp limits.

A read–write–read sequence reuses the writer's stored results as the next reader's input. This exercises the role swap, the direction flip and the wrap of the coefficient set. Stray strobes during the header fetch, on the downstream side and between passes must leave the output and the following results unchanged.

// File: rtl/iirStagePkg.sv
package iirStagePkg;

  typedef enum logic [1:0] {
    MODE_PROP  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } stageModeT;

  typedef enum logic [1:0] {
    SRC_MEM   = 2'd0,
    SRC_LEFT  = 2'd1,
    SRC_RIGHT = 2'd2
  } srcSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic   clearDelay;
    logic   sampleEn;
    srcSelT inSel;
    logic   loadA0;
    logic   loadA1;
    logic   loadB1;
  } dpCtrlT;

  // header: config word, length word, then coefficient sets
  localparam int HdrFixedWords = 2;
  localparam int CoefPerSet    = 3;

endpackage

// File: rtl/iirStageDp.sv
module iirStageDp
  import iirStagePkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrlT           ctl,
  input  logic [DataW-1:0] memRdData,
  input  logic [DataW-1:0] leftInData,
  input  logic [DataW-1:0] rightInData,
  output logic [DataW-1:0] yOut,
  output logic             yValid
);

  localparam int ProdW = 2 * DataW;
  localparam int SumW  = ProdW + 2;
  localparam int ShW   = SumW - (DataW - 1);
  localparam logic signed [ShW-1:0] SatHi = ShW'((2 ** (DataW - 1)) - 1);
  localparam logic signed [ShW-1:0] SatLo = ~SatHi;

  logic signed [DataW-1:0] coefA0, coefA1, coefB1;
  logic signed [DataW-1:0] xDly, yDly;
  logic signed [DataW-1:0] xIn;
  logic signed [ProdW-1:0] prodA0, prodA1, prodB1;
  logic signed [SumW-1:0]  extA0, extA1, extB1, accSum;
  logic signed [ShW-1:0]   shifted;
  logic signed [DataW-1:0] ySat;

  always_comb begin
    case (ctl.inSel)
      SRC_LEFT:  xIn = leftInData;
      SRC_RIGHT: xIn = rightInData;
      default:   xIn = memRdData;
    endcase
  end

  assign prodA0  = coefA0 * xIn;
  assign prodA1  = coefA1 * xDly;
  assign prodB1  = coefB1 * yDly;
  assign extA0   = prodA0;
  assign extA1   = prodA1;
  assign extB1   = prodB1;
  assign accSum  = extA0 + extA1 - extB1;
  assign shifted = accSum[SumW-1:DataW-1];

  always_comb begin
    if (shifted > SatHi)      ySat = SatHi[DataW-1:0];
    else if (shifted < SatLo) ySat = SatLo[DataW-1:0];
    else                      ySat = shifted[DataW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefA0 <= '0;
      coefA1 <= '0;
      coefB1 <= '0;
    end else begin
      if (ctl.loadA0) coefA0 <= memRdData;
      if (ctl.loadA1) coefA1 <= memRdData;
      if (ctl.loadB1) coefB1 <= memRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xDly   <= '0;
      yDly   <= '0;
      yOut   <= '0;
      yValid <= 1'b0;
    end else if (ctl.clearDelay) begin
      xDly   <= '0;
      yDly   <= '0;
      yValid <= 1'b0;
    end else begin
      yValid <= ctl.sampleEn;
      if (ctl.sampleEn) begin
        xDly <= xIn;
        yDly <= ySat;
        yOut <= ySat;
      end
    end
  end

endmodule

// File: rtl/iirStageCtrl.sv
module iirStageCtrl
  import iirStagePkg::*;
#(
  parameter int DataW    = 8,
  parameter int AddrW    = 10,
  parameter int HdrWords = 8,
  parameter int CoefSets = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             leftInStb,
  input  logic             rightInStb,
  input  logic [DataW-1:0] memRdData,
  output dpCtrlT           ctl,
  output logic             memRdEn,
  output logic [AddrW-1:0] rdAddr,
  output logic [AddrW-1:0] wrAddr,
  output logic             dir,
  output logic             isWriter,
  output logic             done
);

  localparam int HdrReads = HdrFixedWords + CoefPerSet;
  localparam int TagW     = $clog2(HdrReads + 1);
  localparam int SetW     = (CoefSets > 1) ? $clog2(CoefSets) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_RUN} ctrlStateT;

  ctrlStateT        state;
  stageModeT        mode;
  logic             firstPass;
  logic [SetW-1:0]  passSet;
  logic [TagW-1:0]  hdrCnt, rdTag;
  logic             rdValid;
  logic [DataW-1:0] passLen, sampCnt, issued;
  logic [AddrW-1:0] hdrAddr;
  logic             hdrIssue, runIssue, hdrLast, capEn, upStb, inRun;

  assign isWriter = (mode == MODE_WRITE);
  assign hdrIssue = (state == ST_HDR) && (hdrCnt < TagW'(HdrReads));
  assign runIssue = (state == ST_RUN) && (mode == MODE_READ) && (issued != passLen);
  assign hdrLast  = (state == ST_HDR) && (hdrCnt == TagW'(HdrReads));
  assign capEn    = rdValid && (state == ST_HDR);
  assign upStb    = dir ? rightInStb : leftInStb;
  assign inRun    = (state == ST_RUN) && (sampCnt != passLen);

  // coefficient words follow the fixed words directly
  assign hdrAddr = (hdrCnt < TagW'(HdrFixedWords)) ? AddrW'(hdrCnt)
                 : AddrW'(CoefPerSet * int'(passSet) + int'(hdrCnt));

  assign memRdEn = hdrIssue || runIssue;
  assign rdAddr  = hdrIssue ? hdrAddr : AddrW'(HdrWords) + AddrW'(issued);

  always_comb begin
    ctl            = '0;
    ctl.clearDelay = hdrLast;
    ctl.loadA0     = capEn && (rdTag == TagW'(HdrFixedWords));
    ctl.loadA1     = capEn && (rdTag == TagW'(HdrFixedWords + 1));
    ctl.loadB1     = capEn && (rdTag == TagW'(HdrFixedWords + 2));
    ctl.sampleEn   = inRun && ((mode == MODE_READ) ? rdValid : upStb);
    if (mode == MODE_READ) ctl.inSel = SRC_MEM;
    else if (dir)          ctl.inSel = SRC_RIGHT;
    else                   ctl.inSel = SRC_LEFT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      mode      <= MODE_PROP;
      dir       <= 1'b0;
      firstPass <= 1'b1;
      passSet   <= '0;
      hdrCnt    <= '0;
      rdTag     <= '0;
      rdValid   <= 1'b0;
      passLen   <= '0;
      sampCnt   <= '0;
      issued    <= '0;
      wrAddr    <= '0;
      done      <= 1'b0;
    end else begin
      done    <= 1'b0;
      rdValid <= memRdEn;
      rdTag   <= hdrCnt;

      if (capEn && rdTag == TagW'(0) && firstPass) begin
        case (memRdData[1:0])
          2'd1:    mode <= MODE_READ;
          2'd2:    mode <= MODE_WRITE;
          default: mode <= MODE_PROP;
        endcase
        dir <= memRdData[2];
      end
      if (capEn && rdTag == TagW'(1)) passLen <= memRdData;

      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_HDR;
            hdrCnt <= '0;
            if (!firstPass) begin
              dir <= ~dir;
              if (mode == MODE_READ)       mode <= MODE_WRITE;
              else if (mode == MODE_WRITE) mode <= MODE_READ;
              passSet <= (passSet == SetW'(CoefSets - 1)) ? '0 : passSet + 1'b1;
            end
          end
        end
        ST_HDR: begin
          if (hdrLast) begin
            state     <= ST_RUN;
            sampCnt   <= '0;
            issued    <= '0;
            firstPass <= 1'b0;
          end else begin
            hdrCnt <= hdrCnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (sampCnt == passLen) begin
            state <= ST_IDLE;
            done  <= isWriter;
          end
          if (runIssue) issued <= issued + 1'b1;
          if (ctl.sampleEn) begin
            sampCnt <= sampCnt + 1'b1;
            wrAddr  <= AddrW'(HdrWords) + AddrW'(sampCnt);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iirReversibleStage.sv
module iirReversibleStage
  import iirStagePkg::*;
#(
  parameter int DataW    = 8,
  parameter int AddrW    = 10,
  parameter int HdrWords = 8,
  parameter int CoefSets = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DataW-1:0] leftInData,
  input  logic             leftInStb,
  input  logic [DataW-1:0] rightInData,
  input  logic             rightInStb,
  output logic [DataW-1:0] leftOutData,
  output logic             leftOutStb,
  output logic [DataW-1:0] rightOutData,
  output logic             rightOutStb,
  output logic [AddrW-1:0] memAddr,
  output logic             memRdEn,
  input  logic [DataW-1:0] memRdData,
  output logic             memWrEn,
  output logic [DataW-1:0] memWrData,
  output logic             done
);

  dpCtrlT           ctl;
  logic [AddrW-1:0] rdAddr, wrAddr;
  logic             dir, isWriter, yValid;
  logic [DataW-1:0] yOut;

  iirStageCtrl #(
    .DataW(DataW), .AddrW(AddrW), .HdrWords(HdrWords), .CoefSets(CoefSets)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .start(start),
    .leftInStb(leftInStb), .rightInStb(rightInStb),
    .memRdData(memRdData), .ctl(ctl), .memRdEn(memRdEn),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .dir(dir),
    .isWriter(isWriter), .done(done)
  );

  iirStageDp #(.DataW(DataW)) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdData(memRdData),
    .leftInData(leftInData), .rightInData(rightInData),
    .yOut(yOut), .yValid(yValid)
  );

  assign memWrEn      = yValid && isWriter;
  assign memWrData    = yOut;
  assign memAddr      = memWrEn ? wrAddr : rdAddr;
  assign rightOutStb  = yValid && !isWriter && !dir;
  assign leftOutStb   = yValid && !isWriter && dir;
  assign rightOutData = rightOutStb ? yOut : '0;
  assign leftOutData  = leftOutStb ? yOut : '0;

endmodule

// File: rtl/iirReversibleStage_chk.sv
module iirReversibleStage_chk #(
  parameter int DataW = 8,
  parameter int AddrW = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             leftInStb,
  input logic             rightInStb,
  input logic             leftOutStb,
  input logic             rightOutStb,
  input logic             memRdEn,
  input logic             memWrEn,
  input logic [AddrW-1:0] memAddr,
  input logic [DataW-1:0] memWrData,
  input logic             done
);

  // R4: results leave on one side only
  p_one_side_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(leftOutStb && rightOutStb));

  // R10: a write cycle never carries a bus strobe
  p_writer_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !(leftOutStb || rightOutStb));

  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: one memory access per cycle
  p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  // R12: every output strobe has an input strobe or a memory read behind it
  p_out_cause_r12: assert property (@(posedge clk) disable iff (!rstN)
    (leftOutStb || rightOutStb) |->
      ($past(leftInStb) || $past(rightInStb) || $past(memRdEn, 2)));

endmodule

bind iirReversibleStage iirReversibleStage_chk #(.DataW(DataW), .AddrW(AddrW)) chkI (
  .clk(clk), .rstN(rstN), .leftInStb(leftInStb), .rightInStb(rightInStb),
  .leftOutStb(leftOutStb), .rightOutStb(rightOutStb), .memRdEn(memRdEn),
  .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData), .done(done)
);

// File: tb/iirReversibleStage_test.sv
`timescale 1ns/1ps
module iirReversibleStage_test;

  localparam int AddrW    = 10;
  localparam int HdrWords = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, start, leftInStb, rightInStb;
  logic [7:0] leftInData, rightInData, leftOutData, rightOutData;
  logic leftOutStb, rightOutStb, memRdEn, memWrEn, done;
  logic [AddrW-1:0] memAddr;
  logic [7:0] memRdData, memWrData;

  iirReversibleStage uut (
    .clk(clk), .rstN(rstN), .start(start),
    .leftInData(leftInData), .leftInStb(leftInStb),
    .rightInData(rightInData), .rightInStb(rightInStb),
    .leftOutData(leftOutData), .leftOutStb(leftOutStb),
    .rightOutData(rightOutData), .rightOutStb(rightOutStb),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .done(done)
  );

  logic [7:0] mem [0:(1<<AddrW)-1];
  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    if (memRdEn) memRdData <= mem[memAddr];
  end

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic signed [7:0] mx1, my1, ca0, ca1, cb1;
  logic signed [7:0] expArr [0:63];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic signed [7:0] modelStep(input logic signed [7:0] a0, a1, b1, x, x1, y1);
    int s;
    s = int'(a0) * int'(x) + int'(a1) * int'(x1) - int'(b1) * int'(y1);
    s = s >>> 7;
    if (s > 127) s = 127;
    else if (s < -128) s = -128;
    return 8'(s);
  endfunction

  task automatic modelRun(input logic signed [7:0] x, output logic signed [7:0] y);
    y = modelStep(ca0, ca1, cb1, x, mx1, my1);
    mx1 = x;
    my1 = y;
  endtask

  task automatic nextRand(output logic signed [7:0] v);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    v = lfsr[7:0];
  endtask

  // R7: set s lives at words 2+3s .. 4+3s; R8: model delays start at zero
  task automatic setCoefs(input int set, input logic signed [7:0] a0, a1, b1);
    mem[2 + 3*set] = a0;
    mem[3 + 3*set] = a1;
    mem[4 + 3*set] = b1;
    ca0 = a0; ca1 = a1; cb1 = b1;
    mx1 = 0; my1 = 0;
  endtask

  task automatic pickCoef(input int k, output logic signed [7:0] a0, a1, b1);
    case (k)
      0: begin a0 = 64;   a1 = 32;  b1 = 0;    end
      1: begin a0 = 96;   a1 = -40; b1 = -64;  end
      2: begin a0 = 127;  a1 = 127; b1 = 0;    end
      3: begin a0 = 50;   a1 = -30; b1 = 100;  end
      4: begin a0 = -128; a1 = 127; b1 = -128; end
      5: begin a0 = 20;   a1 = 20;  b1 = 0;    end
      6: begin a0 = 127;  a1 = 0;   b1 = 127;  end
      default: begin a0 = -77; a1 = 33; b1 = -90; end
    endcase
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // R12: a stray strobe during header fetch must be ignored
  task automatic startPass(input bit strayRight);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    if (strayRight) begin rightInData = 8'd55; rightInStb = 1'b1; end
    else begin leftInData = 8'd55; leftInStb = 1'b1; end
    @(negedge clk);
    leftInStb = 1'b0; rightInStb = 1'b0;
    chk(!leftOutStb && !rightOutStb && !memWrEn, "R12 header-fetch strobe",
        int'(leftOutStb | rightOutStb | memWrEn), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic pushSample(input bit fromRight, input bit writer, input logic signed [7:0] x,
                            input int idx, input bit last, input string req);
    logic signed [7:0] y;
    modelRun(x, y);
    @(negedge clk);
    if (fromRight) begin rightInData = x; rightInStb = 1'b1; end
    else begin leftInData = x; leftInStb = 1'b1; end
    @(negedge clk);
    leftInStb = 1'b0; rightInStb = 1'b0;
    if (writer) begin
      chk(memWrEn === 1'b1, {req, " write strobe"}, int'(memWrEn), 1);
      chk(int'(memAddr) == HdrWords + idx, {req, " write address"}, int'(memAddr), HdrWords + idx);
      chk($signed(memWrData) == y, {req, " write data"}, int'($signed(memWrData)), int'(y));
      chk(!leftOutStb && !rightOutStb, "R10 writer bus quiet", int'(leftOutStb | rightOutStb), 0);
      if (last) begin
        @(negedge clk);
        chk(done === 1'b1, "R11 done after last write", int'(done), 1);
        @(negedge clk);
        chk(done === 1'b0, "R11 done single cycle", int'(done), 0);
      end
    end else if (fromRight) begin
      chk(leftOutStb === 1'b1, {req, " R4 left strobe"}, int'(leftOutStb), 1);
      chk($signed(leftOutData) == y, {req, " left data"}, int'($signed(leftOutData)), int'(y));
      chk(rightOutStb === 1'b0, "R4 upstream side quiet", int'(rightOutStb), 0);
    end else begin
      chk(rightOutStb === 1'b1, {req, " R4 right strobe"}, int'(rightOutStb), 1);
      chk($signed(rightOutData) == y, {req, " right data"}, int'($signed(rightOutData)), int'(y));
      chk(leftOutStb === 1'b0, "R4 upstream side quiet", int'(leftOutStb), 0);
    end
  endtask

  task automatic pushIgnored(input bit onRight, input string req);
    @(negedge clk);
    if (onRight) begin rightInData = 8'd99; rightInStb = 1'b1; end
    else begin leftInData = 8'd99; leftInStb = 1'b1; end
    @(negedge clk);
    leftInStb = 1'b0; rightInStb = 1'b0;
    chk(!leftOutStb && !rightOutStb && !memWrEn, req,
        int'(leftOutStb | rightOutStb | memWrEn), 0);
  endtask

  task automatic readerExpect(input int len);
    logic signed [7:0] y;
    mx1 = 0; my1 = 0;
    for (int i = 0; i < len; i++) begin
      modelRun($signed(mem[HdrWords + i]), y);
      expArr[i] = y;
    end
  endtask

  task automatic collectReader(input int len, input bit toRight, input string req);
    int got;
    int bad;
    got = 0; bad = 0;
    for (int c = 0; c < 4*len + 30; c++) begin
      @(negedge clk);
      if (toRight ? rightOutStb : leftOutStb) begin
        if (got < len) begin
          if (toRight)
            chk($signed(rightOutData) == expArr[got], {req, " reader data"},
                int'($signed(rightOutData)), int'(expArr[got]));
          else
            chk($signed(leftOutData) == expArr[got], {req, " reader data"},
                int'($signed(leftOutData)), int'(expArr[got]));
        end
        got++;
      end
      if ((toRight ? leftOutStb : rightOutStb) || done || memWrEn) bad++;
    end
    chk(got == len, {req, " reader sample count"}, got, len);
    chk(bad == 0, "R11 reader raises no done, wrong side or write", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=150000 expected=fewer cycles");
    finishRun();
  end

  initial begin
    logic signed [7:0] a0, a1, b1, x;
    bit rl;
    string req;
    rstN = 1'b0; start = 1'b0;
    leftInStb = 1'b0; rightInStb = 1'b0;
    leftInData = '0; rightInData = '0;
    for (int i = 0; i < (1<<AddrW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5: reset state
    chk(!leftOutStb && !rightOutStb, "R5 reset strobes", int'(leftOutStb | rightOutStb), 0);
    chk(!memWrEn && !memRdEn, "R5 reset memory idle", int'(memWrEn | memRdEn), 0);
    chk(!done, "R5 reset done", int'(done), 0);

    // Propagate sweep, direction alternates each pass (R6), set alternates (R7)
    mem[0] = 8'd0;
    mem[1] = 8'd10;
    for (int p = 0; p < 8; p++) begin
      rl = p[0];
      pickCoef(p, a0, a1, b1);
      setCoefs(p % 2, a0, a1, b1);
      case (p)
        0: req = "R3";
        1: req = "R6";
        2: req = "R2";
        3: req = "R8";
        4: req = "R7";
        default: req = "R1";
      endcase
      startPass(rl);
      for (int i = 0; i < 10; i++) begin
        if (p == 2) x = (i < 5) ? 8'sd127 : -8'sd128;
        else nextRand(x);
        pushSample(rl, 1'b0, x, i, i == 9, req);
        if (i == 4) pushIgnored(!rl, "R4 downstream strobe ignored");
      end
      repeat (2) @(negedge clk);
      pushIgnored(rl, "R12 strobe between passes ignored");
      chk(!done, "R11 propagator no done", int'(done), 0);
    end

    // Reader -> writer -> reader
    doReset();
    mem[0] = 8'd1;
    mem[1] = 8'd12;
    setCoefs(1, 40, 60, -30);
    setCoefs(0, 70, -20, 45);
    for (int i = 0; i < 12; i++) begin
      nextRand(x);
      mem[HdrWords + i] = x;
    end
    readerExpect(12);
    startPass(1'b0);
    collectReader(12, 1'b1, "R9");

    setCoefs(1, 40, 60, -30);
    startPass(1'b1);
    for (int i = 0; i < 12; i++) begin
      nextRand(x);
      pushSample(1'b1, 1'b1, x, i, i == 11, "R6 R10");
      if (i == 5) pushIgnored(1'b0, "R4 writer downstream strobe ignored");
    end

    setCoefs(0, 70, -20, 45);
    readerExpect(12);
    startPass(1'b0);
    collectReader(12, 1'b1, "R7 R6");

    // Writer first, right-to-left from config bit 2 (R5)
    doReset();
    mem[0] = 8'd6;
    mem[1] = 8'd6;
    setCoefs(0, -90, 50, -70);
    startPass(1'b1);
    for (int i = 0; i < 6; i++) begin
      nextRand(x);
      pushSample(1'b1, 1'b1, x, i, i == 5, "R5 R10");
    end

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule